// File: doc/BRIEF.md
# Predicated Pairwise Floating-Point Vector Adder

This block takes two vector operands and sums neighbouring element pairs. The sums are then woven together: every even result lane holds a pair taken from the first operand, and every odd result lane holds a pair taken from the second operand. The destination is the first operand itself. A lane that the selected predicate does not enable keeps the value it already had in the first operand. The operation therefore works in place, under a mask.

A 2-bit size code picks 16-, 32- or 64-bit IEEE-style elements. The remaining code is reserved: when it is used, the block raises an undefined-operation flag and leaves the destination untouched. The predicate is chosen from a bank of eight predicate registers. Each predicate holds one bit per vector byte. An element is active when the bit at its lowest byte is set.

Each lane adder rounds to nearest-even. It flushes subnormal inputs and outputs to zero and returns a single default quiet NaN. All outputs are registered, so a result appears one clock after its operands are presented.

Top module: `pairwise_fadd`

## Requirements
- R1: `size_code` selects the element width: 2'b01 gives 16-bit (5-bit exponent, 10-bit fraction), 2'b10 gives 32-bit (8/23) and 2'b11 gives 64-bit (11/52). Lane e occupies bits [e*W +: W], so there are VLEN/W lanes.
- R2: `size_code` 2'b00 is reserved. On the following cycle `undef_out` is 1, `dst_out` equals the `src_dn` that was presented and `invalid_out` is 0. For any other code `undef_out` is 0.
- R3: For an active even lane e, the result is element e plus element e+1 of `src_dn`.
- R4: For an active odd lane e, the result is element e-1 plus element e of `src_m`.
- R5: A lane is active when the selected predicate bit at byte index e*W/8 is 1. An inactive lane outputs element e of `src_dn` unchanged. With an all-zero selected predicate, `dst_out` equals `src_dn` and `invalid_out` is 0.
- R6: `pred_sel` (0..7) selects the predicate `pred_bank[pred_sel*VLEN/8 +: VLEN/8]`. The other seven predicates have no effect.
- R7: Finite sums are rounded to nearest, ties to even. A sum whose rounded exponent reaches the all-ones code becomes infinity with the sign of the larger-magnitude addend. Two positive non-NaN addends never give a negative result.
- R8: Inputs with a zero exponent field count as zero with their own sign. Results below the smallest normal become zero with the result's sign. An exact cancellation gives +0, and -0 + -0 gives -0.
- R9: If either addend is a NaN, the lane result is the default quiet NaN: sign 0, exponent all ones, only the top fraction bit set.
- R10: Infinity plus infinity of opposite sign gives the default quiet NaN and raises `invalid_out`, which is the OR over active lanes only. Infinity plus a finite value gives that infinity.
- R11: Outputs are registered with one cycle of latency. A synchronous active-low reset clears `dst_out`, `undef_out` and `invalid_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_code | input | 2 | Element size code (00 reserved) |
| pred_sel | input | 3 | Index of the governing predicate |
| pred_bank | input | 8*VLEN/8 | Eight predicates, one bit per vector byte each |
| src_dn | input | VLEN | First operand, also the merge source for inactive lanes |
| src_m | input | VLEN | Second operand |
| dst_out | output | VLEN | Registered result vector |
| undef_out | output | 1 | Reserved size code was used |
| invalid_out | output | 1 | Opposite infinities were added in an active lane |

## Verification
Random normal operands in every format, under random predicate banks and random selections, are checked against a reference model that works in double-precision real arithmetic. These runs separate the correct pair routing (even lanes from the first operand, odd lanes from the second) from swapped or shifted routings. The random predicates also show that only the lowest-byte bit of each element matters. Directed vectors cover the following cases:
- opposite infinities, NaN, subnormal, overflow, exact-cancellation and tie-rounding operands in known lanes;
- the same vectors with the invalid lane masked off, which shows that the flag follows the predicate;
- a bank in which only one predicate is non-zero, which shows that selection ignores the other registers;
- the reserved size code, which must report the undefined flag and keep the destination unchanged.

// File: rtl/pfa_pkg.sv
// Package: shared types and per-format constants for the pairwise adder.
// Assumes format index 0/1/2 maps to size codes 01/10/11.
package pfa_pkg;

    typedef enum logic [1:0] {
        SZ_RSVD = 2'b00,
        SZ_HALF = 2'b01,
        SZ_SGL  = 2'b10,
        SZ_DBL  = 2'b11
    } size_e;

    localparam int FMT_COUNT  = 3;
    localparam int PRED_REGS  = 8;

    // Exponent width of format index idx
    function automatic int fmt_exp(input int idx);
        return (idx == 0) ? 5 : ((idx == 1) ? 8 : 11);
    endfunction

    // Fraction width of format index idx
    function automatic int fmt_man(input int idx);
        return (idx == 0) ? 10 : ((idx == 1) ? 23 : 52);
    endfunction

    // Total element width of format index idx
    function automatic int fmt_width(input int idx);
        return 1 + fmt_exp(idx) + fmt_man(idx);
    endfunction

endpackage

// File: rtl/pfa_fp_add.sv
// Module: combinational IEEE-style adder for one lane.
// Rounds to nearest-even, flushes subnormal inputs and results to signed
// zero and returns one default quiet NaN. Flags only opposite-infinity sums.
// Assumes EXP_W >= 2 and MAN_W >= 2.
module pfa_fp_add #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    output logic [EXP_W+MAN_W:0] sum_o,
    output logic                 invalid_o
);
    localparam int W  = 1 + EXP_W + MAN_W;
    localparam int FW = MAN_W + 4;          // hidden + fraction + guard/round/sticky
    localparam int XW = EXP_W + 3;          // signed working exponent
    localparam logic [EXP_W-1:0]     EXP_ONES = '1;
    localparam logic [W-1:0]         QNAN     = {1'b0, EXP_ONES, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic signed [XW-1:0] X_ZERO   = '0;
    localparam logic signed [XW-1:0] X_ONE    = XW'(1);
    localparam logic signed [XW-1:0] X_TOP    = $signed({3'b000, EXP_ONES});

    logic             a_s, b_s, a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
    logic [EXP_W-1:0] a_e, b_e, big_e, sml_e, diff;
    logic [MAN_W-1:0] a_m, b_m, big_m, sml_m, rman;
    logic             a_bigger, big_s, eff_sub, round_up, hidden_unused;
    logic [FW-1:0]    big_x, sml_x, sml_al, norm;
    logic [FW:0]      raw;
    logic signed [XW-1:0] lz, nexp, rexp;
    logic [MAN_W+1:0] mant_r;
    logic [W-1:0]     res;
    logic             inv;

    // Field split and class decode of both addends
    assign a_s    = a_i[W-1];
    assign b_s    = b_i[W-1];
    assign a_e    = a_i[W-2:MAN_W];
    assign b_e    = b_i[W-2:MAN_W];
    assign a_m    = a_i[MAN_W-1:0];
    assign b_m    = b_i[MAN_W-1:0];
    assign a_zero = (a_e == '0);
    assign b_zero = (b_e == '0);
    assign a_nan  = (a_e == EXP_ONES) && (a_m != '0);
    assign b_nan  = (b_e == EXP_ONES) && (b_m != '0);
    assign a_inf  = (a_e == EXP_ONES) && (a_m == '0);
    assign b_inf  = (b_e == EXP_ONES) && (b_m == '0);

    // Order operands by magnitude so the subtraction never goes negative
    assign a_bigger = (a_i[W-2:0] >= b_i[W-2:0]);
    assign big_s    = a_bigger ? a_s : b_s;
    assign big_e    = a_bigger ? a_e : b_e;
    assign big_m    = a_bigger ? a_m : b_m;
    assign sml_e    = a_bigger ? b_e : a_e;
    assign sml_m    = a_bigger ? b_m : a_m;
    assign diff     = big_e - sml_e;
    assign big_x    = {1'b1, big_m, 3'b000};
    assign sml_x    = {1'b1, sml_m, 3'b000};
    assign eff_sub  = a_s ^ b_s;

    // Align the smaller significand, folding shifted-out bits into sticky
    always_comb begin
        sml_al = '0;
        if (int'(diff) >= FW) begin
            sml_al[0] = 1'b1;
        end else begin
            sml_al    = sml_x >> diff;
            sml_al[0] = sml_al[0] | (|(sml_x & ~({FW{1'b1}} << diff)));
        end
    end

    // Magnitude add or subtract with one carry bit
    assign raw = eff_sub ? ({1'b0, big_x} - {1'b0, sml_al})
                         : ({1'b0, big_x} + {1'b0, sml_al});

    // Normalise: right by one on carry, left by leading-zero count otherwise
    always_comb begin
        lz = X_ZERO;
        for (int i = 0; i < FW; i++) begin
            if (raw[i]) lz = XW'(FW - 1 - i);
        end
        nexp = $signed({3'b000, big_e});
        norm = raw[FW-1:0];
        if (raw[FW]) begin
            norm    = raw[FW:1];
            norm[0] = raw[1] | raw[0];
            nexp    = nexp + X_ONE;
        end else begin
            norm = raw[FW-1:0] << lz;
            nexp = nexp - lz;
        end
    end

    // Round to nearest-even; a carry out of the fraction bumps the exponent
    assign round_up      = norm[2] & (norm[1] | norm[0] | norm[3]);
    assign mant_r        = {1'b0, norm[FW-1:3]} + {{(MAN_W+1){1'b0}}, round_up};
    assign rexp          = mant_r[MAN_W+1] ? (nexp + X_ONE) : nexp;
    assign rman          = mant_r[MAN_W+1] ? '0 : mant_r[MAN_W-1:0];
    assign hidden_unused = mant_r[MAN_W];

    // Pick the final result by operand class, then guard its sign behaviour
    always_comb begin
        res = '0;
        inv = 1'b0;
        if (a_nan || b_nan) begin
            res = QNAN;
        end else if (a_inf && b_inf && eff_sub) begin
            res = QNAN;
            inv = 1'b1;
        end else if (a_inf) begin
            res = a_i;
        end else if (b_inf) begin
            res = b_i;
        end else if (a_zero && b_zero) begin
            res = {a_s & b_s, {(W-1){1'b0}}};
        end else if (a_zero) begin
            res = b_i;
        end else if (b_zero) begin
            res = a_i;
        end else if (raw == '0) begin
            res = '0;
        end else if (nexp <= X_ZERO) begin
            res = {big_s, {(W-1){1'b0}}};
        end else if (rexp >= X_TOP) begin
            res = {big_s, EXP_ONES, {MAN_W{1'b0}}};
        end else begin
            res = {big_s, rexp[EXP_W-1:0], rman};
        end
        AST_POS_SUM_NOT_NEG: assert (a_s || b_s || a_nan || b_nan || !res[W-1]); // R7
        AST_CANCEL_GIVES_POS_ZERO: assert (!(a_i == {~b_s, b_i[W-2:0]} && !a_nan && !a_inf && !a_zero)
                                           || res == '0); // R8
    end

    assign sum_o     = res;
    assign invalid_o = inv;

endmodule

// File: rtl/pfa_lane_group.sv
// Module: all lanes of one element format across the vector.
// Even lane e adds dn[e] and dn[e+1]; odd lane e adds m[e-1] and m[e].
// Inactive lanes pass dn[e] through. Assumes VLEN is a multiple of 2*W.
module pfa_lane_group #(
    parameter int VLEN  = 256,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [VLEN-1:0]                      dn_i,
    input  logic [VLEN-1:0]                      m_i,
    input  logic [VLEN/(1+EXP_W+MAN_W)-1:0]      act_i,
    output logic [VLEN-1:0]                      res_o,
    output logic                                 invalid_o
);
    localparam int EW    = 1 + EXP_W + MAN_W;
    localparam int LANES = VLEN / EW;

    logic [LANES-1:0] lane_inv;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [EW-1:0] op_x, op_y, sum;
        logic          inv;

        // Route the addend pair by lane parity
        if (e % 2 == 0) begin : g_even
            assign op_x = dn_i[e*EW +: EW];
            assign op_y = dn_i[(e+1)*EW +: EW];
        end else begin : g_odd
            assign op_x = m_i[(e-1)*EW +: EW];
            assign op_y = m_i[e*EW +: EW];
        end

        pfa_fp_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_add (
            .a_i       (op_x),
            .b_i       (op_y),
            .sum_o     (sum),
            .invalid_o (inv)
        );

        // Merge under the predicate; only active lanes may raise the flag
        assign res_o[e*EW +: EW] = act_i[e] ? sum : dn_i[e*EW +: EW];
        assign lane_inv[e]       = act_i[e] & inv;
    end

    assign invalid_o = |lane_inv;

endmodule

// File: rtl/pairwise_fadd.sv
// Module: top of the predicated pairwise floating-point vector adder.
// Selects one of eight predicates, builds every format's result in parallel
// and registers the one picked by the size code. Size code 00 is reserved.
// Assumes VLEN is a multiple of 128.
module pairwise_fadd #(
    parameter int VLEN = 256
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [1:0]                             size_code,
    input  logic [2:0]                             pred_sel,
    input  logic [pfa_pkg::PRED_REGS*(VLEN/8)-1:0] pred_bank,
    input  logic [VLEN-1:0]                        src_dn,
    input  logic [VLEN-1:0]                        src_m,
    output logic [VLEN-1:0]                        dst_out,
    output logic                                   undef_out,
    output logic                                   invalid_out
);
    import pfa_pkg::*;

    localparam int PB = VLEN / 8;

    logic [PB-1:0]   pmask;
    logic [PB/2-1:0] odd_bytes_unused;
    logic [VLEN-1:0] grp_res [FMT_COUNT];
    logic [FMT_COUNT-1:0] grp_inv;
    logic [VLEN-1:0] nxt_dst;
    logic            nxt_und, nxt_inv;

    // Governing predicate chosen from the bank
    assign pmask = pred_bank[pred_sel*PB +: PB];

    // No format starts an element at an odd byte
    for (genvar i = 0; i < PB/2; i++) begin : g_odd_byte
        assign odd_bytes_unused[i] = pmask[2*i+1];
    end

    for (genvar g = 0; g < FMT_COUNT; g++) begin : g_fmt
        localparam int EW = fmt_width(g);
        localparam int LN = VLEN / EW;
        logic [LN-1:0] act;

        // Element activity comes from the bit at its lowest byte
        for (genvar e = 0; e < LN; e++) begin : g_act
            assign act[e] = pmask[e*(EW/8)];
        end

        pfa_lane_group #(
            .VLEN  (VLEN),
            .EXP_W (fmt_exp(g)),
            .MAN_W (fmt_man(g))
        ) u_grp (
            .dn_i      (src_dn),
            .m_i       (src_m),
            .act_i     (act),
            .res_o     (grp_res[g]),
            .invalid_o (grp_inv[g])
        );
    end

    // Select the result of the requested format, or flag the reserved code
    always_comb begin
        nxt_dst = src_dn;
        nxt_und = 1'b0;
        nxt_inv = 1'b0;
        case (size_e'(size_code))
            SZ_HALF: begin nxt_dst = grp_res[0]; nxt_inv = grp_inv[0]; end
            SZ_SGL:  begin nxt_dst = grp_res[1]; nxt_inv = grp_inv[1]; end
            SZ_DBL:  begin nxt_dst = grp_res[2]; nxt_inv = grp_inv[2]; end
            default: nxt_und = 1'b1;
        endcase
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_out     <= '0;
            undef_out   <= 1'b0;
            invalid_out <= 1'b0;
        end else begin
            dst_out     <= nxt_dst;
            undef_out   <= nxt_und;
            invalid_out <= nxt_inv;
        end
    end

    AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 2'b00) |=> undef_out); // R2
    AST_LEGAL_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code != 2'b00) |=> !undef_out); // R1
    AST_RESERVED_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == 2'b00) |=> (dst_out == $past(src_dn) && !invalid_out)); // R2
    AST_EMPTY_PRED_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (pmask == '0) |=> (dst_out == $past(src_dn) && !invalid_out)); // R5

endmodule

// File: tb/pairwise_fadd_bench.sv
// Bench: drives operands at the falling edge and compares every output at
// the next falling edge against a model built on real arithmetic.
module pairwise_fadd_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 256;
    localparam int PB   = VLEN / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        size_code = '0;
    logic [2:0]        pred_sel = '0;
    logic [8*PB-1:0]   pred_bank = '0;
    logic [VLEN-1:0]   src_dn = '0, src_m = '0;
    logic [VLEN-1:0]   dst_out;
    logic              undef_out, invalid_out;
    int                n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pairwise_fadd #(.VLEN(VLEN)) u_pairwise_fadd (
        .clk(clk), .rst_n(rst_n), .size_code(size_code), .pred_sel(pred_sel),
        .pred_bank(pred_bank), .src_dn(src_dn), .src_m(src_m),
        .dst_out(dst_out), .undef_out(undef_out), .invalid_out(invalid_out)
    );

    function automatic int ebits(int k); return (k == 1) ? 5 : ((k == 2) ? 8 : 11); endfunction
    function automatic int mbits(int k); return (k == 1) ? 10 : ((k == 2) ? 23 : 52); endfunction
    function automatic int wbits(int k); return 1 + ebits(k) + mbits(k); endfunction
    function automatic longint bias_of(int k); return (longint'(1) << (ebits(k) - 1)) - 1; endfunction
    function automatic longint emax_of(int k); return (longint'(1) << ebits(k)) - 1; endfunction

    function automatic logic [63:0] mk(int k, logic s, longint e, logic [63:0] m);
        return ({63'd0, s} << (ebits(k) + mbits(k))) | (64'(e) << mbits(k))
               | (m & ((64'd1 << mbits(k)) - 1));
    endfunction

    function automatic real widen(logic [63:0] x, int k);
        int M = mbits(k);
        logic s = x[ebits(k) + M];
        longint e = longint'((x >> M) & ((64'd1 << ebits(k)) - 1));
        logic [63:0] m = x & ((64'd1 << M) - 1);
        logic [63:0] sh = m << (52 - M);
        if (e == 0) return $bitstoreal({s, 63'd0});
        return $bitstoreal({s, 11'(e - bias_of(k) + 1023), sh[51:0]});
    endfunction

    function automatic logic [63:0] narrow(real r, int k);
        int M = mbits(k);
        int sh = 52 - M;
        logic [63:0] b = $realtobits(r);
        logic s = b[63];
        longint de = longint'(b[62:52]);
        logic [63:0] q = {12'd0, b[51:0]};
        logic [63:0] rem, half;
        longint ne;
        if (de == 2047) return mk(k, s, emax_of(k), 64'd0);
        if (de == 0) return mk(k, s, 0, 64'd0);
        ne = de - 1023 + bias_of(k);
        if (sh > 0) begin
            rem  = q & ((64'd1 << sh) - 1);
            half = 64'd1 << (sh - 1);
            q    = q >> sh;
            if (rem > half || (rem == half && q[0])) q = q + 1;
            if (q == (64'd1 << M)) begin q = '0; ne = ne + 1; end
        end
        if (ne >= emax_of(k)) return mk(k, s, emax_of(k), 64'd0);
        if (ne <= 0) return mk(k, s, 0, 64'd0);
        return mk(k, s, ne, q);
    endfunction

    // Returns {invalid, result} for one lane
    function automatic logic [64:0] fadd_model(logic [63:0] x, logic [63:0] y, int k);
        int M = mbits(k);
        longint ex = longint'((x >> M) & ((64'd1 << ebits(k)) - 1));
        longint ey = longint'((y >> M) & ((64'd1 << ebits(k)) - 1));
        logic [63:0] mx = x & ((64'd1 << M) - 1);
        logic [63:0] my = y & ((64'd1 << M) - 1);
        logic [63:0] qnan = mk(k, 1'b0, emax_of(k), 64'd1 << (M - 1));
        logic xi = (ex == emax_of(k)) && (mx == 0);
        logic yi = (ey == emax_of(k)) && (my == 0);
        if ((ex == emax_of(k) && mx != 0) || (ey == emax_of(k) && my != 0)) return {1'b0, qnan};
        if (xi && yi && (x[ebits(k)+M] != y[ebits(k)+M])) return {1'b1, qnan};
        if (xi) return {1'b0, x};
        if (yi) return {1'b0, y};
        return {1'b0, narrow(widen(x, k) + widen(y, k), k)};
    endfunction

    function automatic logic [63:0] lane(logic [VLEN-1:0] v, int e, int w);
        logic [63:0] x = '0;
        for (int i = 0; i < w; i++) x[i] = v[e*w + i];
        return x;
    endfunction

    function automatic logic [VLEN-1:0] put(logic [VLEN-1:0] v, int e, int w, logic [63:0] x);
        for (int i = 0; i < w; i++) v[e*w + i] = x[i];
        return v;
    endfunction

    function automatic logic [63:0] rnd_norm(int k);
        return mk(k, 1'($urandom % 2), bias_of(k) - 6 + longint'($urandom % 13), {$urandom, $urandom});
    endfunction

    function automatic logic [VLEN-1:0] rnd_vec(int k);
        logic [VLEN-1:0] v = '0;
        for (int e = 0; e < VLEN / wbits(k); e++) v = put(v, e, wbits(k), rnd_norm(k));
        return v;
    endfunction

    function automatic logic [8*PB-1:0] rnd_bank();
        logic [8*PB-1:0] b;
        for (int i = 0; i < 8*PB; i++) b[i] = 1'($urandom % 2);
        return b;
    endfunction

    task automatic check(string req, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: drive, model, then compare one edge later
    task automatic run_op(int k, logic [8*PB-1:0] bank, logic [2:0] sel,
                          logic [VLEN-1:0] a, logic [VLEN-1:0] b, string req);
        logic [VLEN-1:0] exp_v = a;
        logic exp_inv = 1'b0;
        logic [PB-1:0] pm = bank[sel*PB +: PB];
        logic [63:0] x, y;
        logic [64:0] r;
        size_code = 2'(k); pred_sel = sel; pred_bank = bank; src_dn = a; src_m = b;
        if (k != 0) begin
            for (int e = 0; e < VLEN / wbits(k); e++) begin
                if (pm[e * wbits(k) / 8]) begin
                    x = (e % 2 == 0) ? lane(a, e, wbits(k)) : lane(b, e - 1, wbits(k));
                    y = (e % 2 == 0) ? lane(a, e + 1, wbits(k)) : lane(b, e, wbits(k));
                    r = fadd_model(x, y, k);
                    exp_v = put(exp_v, e, wbits(k), r[63:0]);
                    exp_inv = exp_inv | r[64];
                end
            end
        end
        @(negedge clk);
        check(req, "dst_out", dst_out, exp_v);
        check("R1/R2", "undef_out", VLEN'(undef_out), VLEN'(k == 0));
        check("R10", "invalid_out", VLEN'(invalid_out), VLEN'(exp_inv));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] a, b;
        logic [8*PB-1:0] bank;
        logic [63:0] v;

        // R11: reset clears every output while operands are live
        size_code = 2'b10; pred_bank = '1; src_dn = rnd_vec(2); src_m = rnd_vec(2);
        repeat (3) @(negedge clk);
        check("R11", "reset dst_out", dst_out, '0);
        check("R11", "reset flags", VLEN'({undef_out, invalid_out}), '0);
        rst_n = 1'b1;

        // R1 R3 R4 R5 R6 R7: random operands, random banks and selections
        for (int k = 1; k <= 3; k++) begin
            for (int n = 0; n < 60; n++)
                run_op(k, rnd_bank(), 3'($urandom % 8), rnd_vec(k), rnd_vec(k), "R1/R3/R4/R5/R6/R7");
            run_op(k, '1, 3'd2, rnd_vec(k), rnd_vec(k), "R3/R4 all active");
            run_op(k, '0, 3'd6, rnd_vec(k), rnd_vec(k), "R5 none active");
        end

        // R6: only predicate 5 is non-zero
        bank = '0; bank[5*PB +: PB] = '1;
        run_op(2, bank, 3'd5, rnd_vec(2), rnd_vec(2), "R6 chosen predicate");
        run_op(2, bank, 3'd4, rnd_vec(2), rnd_vec(2), "R6 other predicate");

        for (int k = 1; k <= 3; k++) begin
            int w = wbits(k);
            // R9 R10: a = {+inf,-inf,NaN,1.0}; R8: subnormal + 1.0 in odd lane 1
            a = rnd_vec(k); b = rnd_vec(k);
            a = put(a, 0, w, mk(k, 0, emax_of(k), 0));
            a = put(a, 1, w, mk(k, 1, emax_of(k), 0));
            a = put(a, 2, w, mk(k, 0, emax_of(k), 1));
            a = put(a, 3, w, mk(k, 0, bias_of(k), 0));
            b = put(b, 0, w, mk(k, 0, 0, 1));
            b = put(b, 1, w, mk(k, 0, bias_of(k), 0));
            b = put(b, 2, w, mk(k, 0, emax_of(k), 0));
            b = put(b, 3, w, mk(k, 1, bias_of(k), 0));
            run_op(k, '1, 3'd0, a, b, "R8/R9/R10 specials");
            // R10: lane 0 inactive, so no flag and +inf kept
            bank = '1; bank[3*PB] = 1'b0;
            run_op(k, bank, 3'd3, a, b, "R10 masked invalid");
            // R8 cancel, R7 overflow and ties to even
            a = rnd_vec(k); b = rnd_vec(k);
            v = rnd_norm(k);
            a = put(a, 0, w, v);
            a = put(a, 1, w, v ^ (64'd1 << (w - 1)));
            a = put(a, 2, w, mk(k, 0, emax_of(k) - 1, '1));
            a = put(a, 3, w, mk(k, 0, emax_of(k) - 1, '1));
            b = put(b, 0, w, mk(k, 0, bias_of(k), 0));
            b = put(b, 1, w, mk(k, 0, bias_of(k) - mbits(k) - 1, 0));
            b = put(b, 2, w, mk(k, 0, bias_of(k), 1));
            b = put(b, 3, w, mk(k, 0, bias_of(k) - mbits(k) - 1, 0));
            run_op(k, '1, 3'd7, a, b, "R7/R8 rounding and cancel");
        end

        // R2: reserved code keeps the destination, even with opposite infinities
        for (int n = 0; n < 4; n++) begin
            a = rnd_vec(2);
            a = put(a, 0, 32, mk(2, 0, 255, 0));
            a = put(a, 1, 32, mk(2, 1, 255, 0));
            run_op(0, '1, 3'(n), a, rnd_vec(2), "R2 reserved size");
        end
        run_op(1, '1, 3'd1, rnd_vec(1), rnd_vec(1), "R1 recovery after reserved");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule